// File: doc/BRIEF.md
# Shadow State Address Generator and Field Extractor

This block serves a per-word memory monitoring scheme in which every aligned data word owns a small state field (1, 2 or 4 bits) kept in a reserved shadow region of the address space. Given a data address, it computes the address of the shadow byte that holds the word's state. This is a programmable base plus the data address shifted right by an amount that depends on the state width. The block then picks the word's field out of the shadow byte returned by the state cache, and builds a write-back byte in which only that field is replaced by a new state value.

All inputs are presented together with a valid strobe. The shadow address, the extracted state and the merged byte appear one clock later and stay unchanged until the next valid input. Only whole-word accesses are handled, so the two lowest address bits never affect any result. The cache that stores the shadow bytes is outside this block.

Top module: `shadow_state_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `rst_n` is low, `out_valid`, `state_addr`, `state_val` and `merged_byte` are cleared to zero at the clock edge.
- R2: `state_addr` equals `state_base` plus `data_addr` shifted right by 5, 4 or 3 when `bpw_mode` is 0, 1 or 2. Mode 0 means 1 state bit per word, mode 1 means 2 bits and mode 2 means 4 bits.
- R3: The field index is `data_addr[4:2]` in mode 0, `data_addr[3:2]` in mode 1 and `data_addr[2]` in mode 2. Field i occupies shadow byte bits starting at i times the field width.
- R4: `state_val` holds the selected field of `state_byte`, zero-extended to 4 bits.
- R5: `merged_byte` equals `state_byte` with only the selected field replaced by the low field-width bits of `new_state`. The other bits of `new_state` are ignored.
- R6: `data_addr[1:0]` has no effect on any output.
- R7: `bpw_mode` value 3 behaves exactly like mode 2 (4 bits per word).
- R8: In a cycle with `in_valid` low, `state_addr`, `state_val` and `merged_byte` keep their values on the next cycle.
- R9: The shadow address sum wraps modulo 2 to the power of `ADDR_W`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inputs on this cycle are to be processed |
| bpw_mode | input | 2 | State bits per word: 0 = 1, 1 = 2, 2 or 3 = 4 |
| state_base | input | ADDR_W | Base address of the shadow region |
| data_addr | input | ADDR_W | Word-aligned data address being checked |
| state_byte | input | 8 | Shadow byte returned by the state cache |
| new_state | input | 4 | State value to insert for write-back |
| out_valid | output | 1 | Registered results are fresh |
| state_addr | output | ADDR_W | Address of the shadow byte |
| state_val | output | 4 | Extracted state field, zero-extended |
| merged_byte | output | 8 | Shadow byte with the selected field replaced |

## Verification
The bench goes after the field positions at both ends of the byte in each width: index 0 and index 7 for 1-bit fields, index 3 for 2-bit fields, and the upper nibble for 4-bit fields. A design that swapped the index order or multiplied by the wrong width would return a neighbour word's state and corrupt that neighbour on write-back. It also drives unaligned low address bits, the reserved mode value, a base that makes the sum overflow, and a new state with stray upper bits. A design that let any of these leak through would show a shifted address, a wrong width or altered bits outside the field. A hold test changes every input with the strobe low. A design that loaded its registers anyway would show new values at the outputs.

// File: rtl/shadow_pkg.sv
// Package: shared types and helpers for the shadow state unit.
// Assumes data words of 2**WORD_LG bytes and an 8-bit shadow byte.
package shadow_pkg;

    // State bits per word, as selected by the mode input.
    typedef enum logic [1:0] {
        BPW_1   = 2'd0,
        BPW_2   = 2'd1,
        BPW_4   = 2'd2,
        BPW_4_R = 2'd3
    } bpw_e;

    // Number of address bits that index a field inside the shadow byte.
    function automatic int unsigned idx_bits(bpw_e m);
        case (m)
            BPW_1:   return 3;
            BPW_2:   return 2;
            default: return 1;
        endcase
    endfunction

    // Field width in bits for a mode.
    function automatic int unsigned field_w(bpw_e m);
        case (m)
            BPW_1:   return 1;
            BPW_2:   return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/shadow_addr_gen.sv
// Module: shadow_addr_gen
// Purpose: forms the shadow byte address as base + (data address >> shift),
//          the shift being word offset bits plus field-index bits.
// Assumes: word-granular accesses; sum wraps at ADDR_W bits.
module shadow_addr_gen
    import shadow_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WORD_LG = 2
) (
    input  bpw_e              mode,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] shadow_addr
);
    localparam int BYTE_LG = 3;
    localparam int NMODES  = 3;

    logic [ADDR_W-1:0] shifted [NMODES];

    // One pre-shifted copy of the address per supported width.
    for (genvar g = 0; g < NMODES; g++) begin : g_shift
        localparam int SH = WORD_LG + BYTE_LG - g;
        assign shifted[g] = addr >> SH;
    end

    // Pick the shift for the mode and add the base.
    always_comb begin
        case (mode)
            BPW_1:   shadow_addr = base + shifted[0];
            BPW_2:   shadow_addr = base + shifted[1];
            default: shadow_addr = base + shifted[2];
        endcase
    end

endmodule

// File: rtl/field_locator.sv
// Module: field_locator
// Purpose: turns the in-byte index bits of the address into the field's
//          lowest bit position and an 8-bit mask covering the field.
// Assumes: idx carries address bits above the word offset (3 bits).
module field_locator
    import shadow_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int LSB_W = $clog2(BYTE_W)
) (
    input  bpw_e              mode,
    input  logic [LSB_W-1:0]  idx,
    output logic [LSB_W-1:0]  lsb,
    output logic [BYTE_W-1:0] mask,
    output logic [BYTE_W-1:0] wmask
);
    // Position of the field: index times field width, index truncated per mode.
    always_comb begin
        case (mode)
            BPW_1: begin
                lsb   = idx;
                wmask = BYTE_W'(8'h01);
            end
            BPW_2: begin
                lsb   = {idx[LSB_W-2:0], 1'b0};
                wmask = BYTE_W'(8'h03);
            end
            default: begin
                lsb   = {idx[0], {(LSB_W-1){1'b0}}};
                wmask = BYTE_W'(8'h0F);
            end
        endcase
    end

    // Mask of the field inside the byte.
    assign mask = wmask << lsb;

endmodule

// File: rtl/field_mux.sv
// Module: field_mux
// Purpose: extracts the selected field from the shadow byte and builds the
//          write-back byte with only that field replaced.
// Assumes: lsb/mask/wmask come from field_locator for the same mode.
module field_mux #(
    parameter int BYTE_W  = 8,
    parameter int STATE_W = 4,
    localparam int LSB_W  = $clog2(BYTE_W)
) (
    input  logic [BYTE_W-1:0]  sbyte,
    input  logic [STATE_W-1:0] nstate,
    input  logic [LSB_W-1:0]   lsb,
    input  logic [BYTE_W-1:0]  mask,
    input  logic [BYTE_W-1:0]  wmask,
    output logic [STATE_W-1:0] val,
    output logic [BYTE_W-1:0]  merged
);
    logic [BYTE_W-1:0] down;
    logic [BYTE_W-1:0] ins;

    // Extract: move field to bit 0 and clear the rest.
    always_comb begin
        down = (sbyte >> lsb) & wmask;
        val  = down[STATE_W-1:0];
    end

    // Merge: clear the field, insert the trimmed new state.
    always_comb begin
        ins    = ({{(BYTE_W-STATE_W){1'b0}}, nstate} & wmask) << lsb;
        merged = (sbyte & ~mask) | ins;
    end

endmodule

// File: rtl/shadow_state_unit.sv
// Module: shadow_state_unit (top)
// Purpose: registered shadow address generation and state field extract/merge.
// Assumes: word-granular accesses only; all inputs valid with in_valid;
//          results appear one cycle later and hold while in_valid is low.
module shadow_state_unit
    import shadow_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WORD_LG = 2,
    parameter int BYTE_W  = 8,
    parameter int STATE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         bpw_mode,
    input  logic [ADDR_W-1:0]  state_base,
    input  logic [ADDR_W-1:0]  data_addr,
    input  logic [BYTE_W-1:0]  state_byte,
    input  logic [STATE_W-1:0] new_state,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  state_addr,
    output logic [STATE_W-1:0] state_val,
    output logic [BYTE_W-1:0]  merged_byte
);
    localparam int LSB_W = $clog2(BYTE_W);

    bpw_e               mode;
    logic [ADDR_W-1:0]  addr_c;
    logic [LSB_W-1:0]   lsb_c;
    logic [BYTE_W-1:0]  mask_c;
    logic [BYTE_W-1:0]  wmask_c;
    logic [STATE_W-1:0] val_c;
    logic [BYTE_W-1:0]  merged_c;

    assign mode = bpw_e'(bpw_mode);

    shadow_addr_gen #(
        .ADDR_W  (ADDR_W),
        .WORD_LG (WORD_LG)
    ) u_addr (
        .mode        (mode),
        .base        (state_base),
        .addr        (data_addr),
        .shadow_addr (addr_c)
    );

    field_locator #(
        .BYTE_W (BYTE_W)
    ) u_loc (
        .mode  (mode),
        .idx   (data_addr[WORD_LG +: LSB_W]),
        .lsb   (lsb_c),
        .mask  (mask_c),
        .wmask (wmask_c)
    );

    field_mux #(
        .BYTE_W  (BYTE_W),
        .STATE_W (STATE_W)
    ) u_mux (
        .sbyte  (state_byte),
        .nstate (new_state),
        .lsb    (lsb_c),
        .mask   (mask_c),
        .wmask  (wmask_c),
        .val    (val_c),
        .merged (merged_c)
    );

    // Valid pipeline flag.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result registers, loaded only on a valid input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_addr  <= '0;
            state_val   <= '0;
            merged_byte <= '0;
        end else if (in_valid) begin
            state_addr  <= addr_c;
            state_val   <= val_c;
            merged_byte <= merged_c;
        end
    end

endmodule

// Module: shadow_state_unit_chk
// Purpose: temporal checks on the top-level ports; bound below.
module shadow_state_unit_chk #(
    parameter int ADDR_W  = 32,
    parameter int BYTE_W  = 8,
    parameter int STATE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [1:0]         bpw_mode,
    input logic [ADDR_W-1:0]  state_base,
    input logic [ADDR_W-1:0]  data_addr,
    input logic [BYTE_W-1:0]  state_byte,
    input logic               out_valid,
    input logic [ADDR_W-1:0]  state_addr,
    input logic [STATE_W-1:0] state_val,
    input logic [BYTE_W-1:0]  merged_byte
);
    logic [2:0]        sh_now;
    logic [BYTE_W-1:0] keep_now;

    // Independent expectation of shift and of the bits outside the field.
    always_comb begin
        case (bpw_mode)
            2'd0: begin
                sh_now   = 3'd5;
                keep_now = ~(BYTE_W'(1) << data_addr[4:2]);
            end
            2'd1: begin
                sh_now   = 3'd4;
                keep_now = ~(BYTE_W'(3) << (2 * data_addr[3:2]));
            end
            default: begin
                sh_now   = 3'd3;
                keep_now = data_addr[2] ? BYTE_W'(8'h0F) : BYTE_W'(8'hF0);
            end
        endcase
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && state_addr == '0 && merged_byte == '0)); // R1

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1

    AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> state_addr == ADDR_W'($past(state_base) + ($past(data_addr) >> $past(sh_now)))); // R2

    AST_ONE_BIT_VAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bpw_mode == 2'd0) |=> state_val[STATE_W-1:1] == '0); // R4

    AST_MERGE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((merged_byte ^ $past(state_byte)) & $past(keep_now)) == '0); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(state_addr) && $stable(state_val) && $stable(merged_byte))); // R8

endmodule

bind shadow_state_unit shadow_state_unit_chk #(
    .ADDR_W  (ADDR_W),
    .BYTE_W  (BYTE_W),
    .STATE_W (STATE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .bpw_mode    (bpw_mode),
    .state_base  (state_base),
    .data_addr   (data_addr),
    .state_byte  (state_byte),
    .out_valid   (out_valid),
    .state_addr  (state_addr),
    .state_val   (state_val),
    .merged_byte (merged_byte)
);

// File: tb/test_shadow_state_unit.sv
// Bench: vector table walked by one loop, then directed reset/hold tests.
module test_shadow_state_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  bpw_mode;
    logic [31:0] state_base;
    logic [31:0] data_addr;
    logic [7:0]  state_byte;
    logic [3:0]  new_state;
    logic        out_valid;
    logic [31:0] state_addr;
    logic [3:0]  state_val;
    logic [7:0]  merged_byte;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct packed {
        logic [1:0]  mode;
        logic [31:0] base;
        logic [31:0] addr;
        logic [7:0]  sb;
        logic [3:0]  ns;
        logic [31:0] ea;
        logic [3:0]  ev;
        logic [7:0]  em;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        // 2-bit, index 3 (top field)
        '{2'd1, 32'hF000_0000, 32'h0000_ABCD, 8'h9C, 4'h1, 32'hF000_0ABC, 4'h2, 8'h5C},
        // 1-bit, index 5
        '{2'd0, 32'h1000_0000, 32'h0000_1234, 8'h20, 4'h0, 32'h1000_0091, 4'h1, 8'h00},
        // 4-bit, upper nibble
        '{2'd2, 32'h8000_0000, 32'h0000_0104, 8'hA5, 4'h3, 32'h8000_0020, 4'hA, 8'h35},
        // R7: mode 3 acts as 4-bit, lower nibble
        '{2'd3, 32'h0000_0000, 32'h0000_0010, 8'hA5, 4'hF, 32'h0000_0002, 4'h5, 8'hAF},
        // R9: sum wraps
        '{2'd1, 32'hFFFF_FFF0, 32'h0000_0200, 8'hFF, 4'h0, 32'h0000_0010, 4'h3, 8'hFC},
        // R6: low address bits 11 ignored, same results as first vector
        '{2'd1, 32'hF000_0000, 32'h0000_ABCF, 8'h9C, 4'h1, 32'hF000_0ABC, 4'h2, 8'h5C},
        // R6: low address bits 00 ignored, same results as first vector
        '{2'd1, 32'hF000_0000, 32'h0000_ABCC, 8'h9C, 4'h1, 32'hF000_0ABC, 4'h2, 8'h5C},
        // 1-bit index 0, stray new_state bits dropped, low bits ignored
        '{2'd0, 32'h2000_0000, 32'h0000_0003, 8'hFE, 4'hF, 32'h2000_0000, 4'h0, 8'hFF},
        // 1-bit index 7 (top bit)
        '{2'd0, 32'h2000_0000, 32'h0000_001C, 8'h7F, 4'h1, 32'h2000_0000, 4'h0, 8'hFF},
        // 2-bit index 1
        '{2'd1, 32'h0000_0000, 32'h0000_0004, 8'h0C, 4'h2, 32'h0000_0000, 4'h3, 8'h08}
    };

    shadow_state_unit i_shadow_state_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .bpw_mode    (bpw_mode),
        .state_base  (state_base),
        .data_addr   (data_addr),
        .state_byte  (state_byte),
        .new_state   (new_state),
        .out_valid   (out_valid),
        .state_addr  (state_addr),
        .state_val   (state_val),
        .merged_byte (merged_byte)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        @(negedge clk);
        in_valid   = vld;
        bpw_mode   = v.mode;
        state_base = v.base;
        data_addr  = v.addr;
        state_byte = v.sb;
        new_state  = v.ns;
    endtask

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0;
        bpw_mode = 2'd0;
        state_base = '0;
        data_addr = '0;
        state_byte = '0;
        new_state = '0;
        // Reset with a valid input present: reset must win.
        @(negedge clk);
        in_valid = 1'b1;
        data_addr = 32'hFFFF_FFFF;
        state_base = 32'h1234_5678;
        state_byte = 8'hFF;
        new_state = 4'hF;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset out_valid", 32'(out_valid), 32'd0);
        check("R1 reset state_addr", state_addr, 32'd0);
        check("R1 reset state_val", 32'(state_val), 32'd0);
        check("R1 reset merged_byte", 32'(merged_byte), 32'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // Table walk: R2 address, R3/R4 extraction, R5 merge.
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i], 1'b1);
            @(negedge clk);
            in_valid = 1'b0;
            check("R1 out_valid after strobe", 32'(out_valid), 32'd1);
            check("R2 state_addr", state_addr, VECS[i].ea);
            check("R3 R4 state_val", 32'(state_val), 32'(VECS[i].ev));
            check("R5 merged_byte", 32'(merged_byte), 32'(VECS[i].em));
        end

        // R8: idle cycle with different inputs leaves outputs held.
        drive(VECS[2], 1'b1);
        drive(VECS[1], 1'b0);
        @(negedge clk);
        check("R1 out_valid low when idle", 32'(out_valid), 32'd0);
        check("R8 state_addr held", state_addr, VECS[2].ea);
        check("R8 state_val held", 32'(state_val), 32'(VECS[2].ev));
        check("R8 merged_byte held", 32'(merged_byte), 32'(VECS[2].em));

        // Back-to-back strobes: each result one cycle after its input.
        drive(VECS[0], 1'b1);
        drive(VECS[3], 1'b1);
        check("R2 back-to-back first", state_addr, VECS[0].ea);
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 back-to-back second", state_addr, VECS[3].ea);
        check("R7 back-to-back value", 32'(state_val), 32'(VECS[3].ev));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule